// File: doc/BRIEF.md
# Masked Interrupt Arbiter with Vectored Entry

This block gathers level-sensitive hardware interrupt lines into a pending-status word, one bit per line. A line update names a line index and a level. An in-range index copies the level into that line's status bit. An index beyond the last line leaves the status word untouched. The status word is filtered through a local-enable mask, which is sampled into a register every cycle. The highest-numbered surviving line is chosen as the vector.

From that vector the block computes the handler address. The handler slots follow a fixed block of exception codes in one evenly spaced entry table. The address is the entry base plus the product of (base code + vector) and the spacing value. The block also reports three things: a raw request when any status bit is set, and a wake flag when a masked pending line exists, whatever the global enable says. It also gives a one-cycle take strobe. The strobe fires when interrupts become both enabled and pending. Enabled means the global enable is set and the debug-state flag is clear.

Top module: `irq_vec_ctrl`

## Requirements
- R1: A line update with `upd_vld` high and `upd_idx` below NUM_LINES writes `upd_lvl` into status bit `upd_idx` at the clock edge. A 1 sets the bit and a 0 clears it, and the new value is visible in the outputs after that edge.
- R2: A line update whose `upd_idx` is NUM_LINES or more changes no status bit.
- R3: `hw_req` is high exactly when at least one status bit is set, regardless of the mask and the enables.
- R4: `take` is never high unless `glob_ie` is 1 and `dbg_state` is 0.
- R5: The mask applied is the value `lie_mask` had at the previous clock edge. A line is pending when its status bit and its mask bit are both 1.
- R6: `vec_num` is the index of the highest-numbered pending line (bit 12 outranks bit 0), and it is 0 when no line is pending.
- R7: `target_addr` equals `entry_base + (EXT_CODE + vec_num) * vec_space`, taken modulo 2^ADDR_W.
- R8: `wake` is high exactly when `hw_req` is high and some line is pending, independent of `glob_ie` and `dbg_state`.
- R9: `take` is high for a single cycle when the condition (enabled and pending) rises. It stays low while the condition holds, and it fires again after the condition has been low across a clock edge.
- R10: A synchronous active-high `rst` clears the status and mask registers. After reset, `hw_req`, `wake`, `take` and `vec_num` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_vld | input | 1 | Line update strobe |
| upd_idx | input | IDX_W | Line index of the update |
| upd_lvl | input | 1 | Level written to the indexed line |
| lie_mask | input | NUM_LINES | Local-enable mask, registered each cycle |
| glob_ie | input | 1 | Global interrupt enable |
| dbg_state | input | 1 | Debug-state flag; blocks taking |
| vec_space | input | SPACE_W | Spacing between entry slots |
| entry_base | input | ADDR_W | Entry table base address |
| hw_req | output | 1 | Any status bit set |
| wake | output | 1 | Request with a masked pending line |
| take | output | 1 | One-cycle take strobe |
| vec_num | output | VEC_W | Selected vector number |
| target_addr | output | ADDR_W | Handler address |

## Verification
The bench builds the block with 13 lines and a 4-bit update index. This leaves indices 13 to 15 free to probe the rule that out-of-range updates are ignored. It uses a 3-bit spacing field, so spacings of 0 through 7 can be driven, including a zero spacing that collapses every slot onto the base. The 32-bit address width, with the default base code of 64, lets a base near the top of the address space show wrap-around of the handler sum.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

    localparam int unsigned DEF_LINES    = 13;
    localparam int unsigned DEF_IDX_W    = 4;
    localparam int unsigned DEF_ADDR_W   = 32;
    localparam int unsigned DEF_SPACE_W  = 3;
    localparam int unsigned DEF_EXT_CODE = 64;

    // Tracks whether the current enabled-and-pending episode already fired.
    typedef enum logic {
        ARM_READY = 1'b0,
        ARM_SPENT = 1'b1
    } arm_state_e;

    function automatic logic gate_open(input logic ie, input logic dbg);
        return ie & ~dbg;
    endfunction

    function automatic int unsigned vec_width(input int unsigned lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

endpackage

// File: rtl/irq_line_status.sv
module irq_line_status #(
    parameter int unsigned NUM_LINES = irq_vec_pkg::DEF_LINES,
    parameter int unsigned IDX_W     = irq_vec_pkg::DEF_IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_vld,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic                 upd_lvl,
    input  logic [NUM_LINES-1:0] lie_mask,
    output logic [NUM_LINES-1:0] status_q,
    output logic [NUM_LINES-1:0] mask_q
);

    // One flop per line; an index that matches no line writes nothing.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (upd_vld && (upd_idx == IDX_W'(g))) begin
                bit_q <= upd_lvl;
            end
        end
        assign status_q[g] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else begin
            mask_q <= lie_mask;
        end
    end

    assert_line_write_R1: assert property (@(posedge clk) disable iff (rst)
        (upd_vld && (32'(upd_idx) < NUM_LINES))
        |=> status_q[$past(upd_idx)] == $past(upd_lvl));

    assert_ignore_range_R2: assert property (@(posedge clk) disable iff (rst)
        !(upd_vld && (32'(upd_idx) < NUM_LINES)) |=> $stable(status_q));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_q == '0 && mask_q == '0));

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int unsigned NUM_LINES = irq_vec_pkg::DEF_LINES,
    parameter int unsigned VEC_W     = irq_vec_pkg::vec_width(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] masked,
    output logic [VEC_W-1:0]     vec,
    output logic                 any
);

    // Ascending scan: the last set bit seen is the highest-numbered one.
    always_comb begin
        vec = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (masked[i]) begin
                vec = VEC_W'(i);
            end
        end
    end

    assign any = |masked;

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int unsigned ADDR_W   = irq_vec_pkg::DEF_ADDR_W,
    parameter int unsigned SPACE_W  = irq_vec_pkg::DEF_SPACE_W,
    parameter int unsigned VEC_W    = 4,
    parameter int unsigned EXT_CODE = irq_vec_pkg::DEF_EXT_CODE
) (
    input  logic [ADDR_W-1:0]  entry_base,
    input  logic [VEC_W-1:0]   vec,
    input  logic [SPACE_W-1:0] vec_space,
    output logic [ADDR_W-1:0]  target_addr
);

    localparam logic [ADDR_W-1:0] CODE_BASE = ADDR_W'(EXT_CODE);

    logic [ADDR_W-1:0] slot_code;
    logic [ADDR_W-1:0] slot_off;

    assign slot_code   = CODE_BASE + ADDR_W'(vec);
    assign slot_off    = slot_code * ADDR_W'(vec_space);
    assign target_addr = entry_base + slot_off;

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_vec_pkg::*;
#(
    parameter int unsigned NUM_LINES = DEF_LINES,
    parameter int unsigned IDX_W     = DEF_IDX_W,
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned SPACE_W   = DEF_SPACE_W,
    parameter int unsigned EXT_CODE  = DEF_EXT_CODE,
    localparam int unsigned VEC_W    = vec_width(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 upd_vld,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic                 upd_lvl,
    input  logic [NUM_LINES-1:0] lie_mask,
    input  logic                 glob_ie,
    input  logic                 dbg_state,
    input  logic [SPACE_W-1:0]   vec_space,
    input  logic [ADDR_W-1:0]    entry_base,
    output logic                 hw_req,
    output logic                 wake,
    output logic                 take,
    output logic [VEC_W-1:0]     vec_num,
    output logic [ADDR_W-1:0]    target_addr
);

    logic [NUM_LINES-1:0] status_w;
    logic [NUM_LINES-1:0] mask_w;
    logic [NUM_LINES-1:0] masked_w;
    logic                 pend_w;
    logic                 cond_w;
    arm_state_e           arm_q;

    irq_line_status #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_status (
        .clk      (clk),
        .rst      (rst),
        .upd_vld  (upd_vld),
        .upd_idx  (upd_idx),
        .upd_lvl  (upd_lvl),
        .lie_mask (lie_mask),
        .status_q (status_w),
        .mask_q   (mask_w)
    );

    assign masked_w = status_w & mask_w;

    irq_prio_pick #(
        .NUM_LINES (NUM_LINES),
        .VEC_W     (VEC_W)
    ) u_pick (
        .masked (masked_w),
        .vec    (vec_num),
        .any    (pend_w)
    );

    irq_vec_addr #(
        .ADDR_W   (ADDR_W),
        .SPACE_W  (SPACE_W),
        .VEC_W    (VEC_W),
        .EXT_CODE (EXT_CODE)
    ) u_addr (
        .entry_base  (entry_base),
        .vec         (vec_num),
        .vec_space   (vec_space),
        .target_addr (target_addr)
    );

    assign hw_req = |status_w;
    assign wake   = hw_req & pend_w;
    assign cond_w = gate_open(glob_ie, dbg_state) & pend_w;

    // Strobe on the first cycle of each enabled-and-pending episode.
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_q <= ARM_READY;
        end else begin
            arm_q <= cond_w ? ARM_SPENT : ARM_READY;
        end
    end

    assign take = cond_w && (arm_q == ARM_READY);

    assert_take_gate_R4: assert property (@(posedge clk) disable iff (rst)
        take |-> (glob_ie && !dbg_state));

    assert_take_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    assert_vec_top_R6: assert property (@(posedge clk) disable iff (rst)
        wake |-> ((masked_w >> vec_num) == NUM_LINES'(1)));

    assert_wake_req_R8: assert property (@(posedge clk) disable iff (rst)
        wake |-> (hw_req && (status_w[vec_num] && mask_w[vec_num])));

    assert_target_steady_R7: assert property (@(posedge clk) disable iff (rst)
        ($stable(entry_base) && $stable(vec_space) && $stable(vec_num))
        |-> $stable(target_addr));

endmodule

// File: tb/irq_vec_ctrl_bench.sv
module irq_vec_ctrl_bench;

    localparam int unsigned N  = 13;
    localparam int unsigned AW = 32;

    typedef struct packed {
        logic [12:0] st;
        logic [12:0] mk;
        logic        ie;
        logic        dbg;
        logic [31:0] base;
        logic [2:0]  sp;
        logic [3:0]  vec;
        logic        wk;
        logic        tk;
    } row_t;

    localparam row_t TBL [8] = '{
        '{13'h0001, 13'h1FFF, 1'b1, 1'b0, 32'h0000_1000, 3'd1, 4'd0,  1'b1, 1'b1},
        '{13'h1001, 13'h1FFF, 1'b1, 1'b0, 32'h0000_2000, 3'd4, 4'd12, 1'b1, 1'b1},
        '{13'h1001, 13'h0FFF, 1'b1, 1'b0, 32'h0000_0000, 3'd2, 4'd0,  1'b1, 1'b1},
        '{13'h0480, 13'h1FFF, 1'b1, 1'b1, 32'h0000_0100, 3'd7, 4'd10, 1'b1, 1'b0},
        '{13'h0480, 13'h0080, 1'b0, 1'b0, 32'h0000_0040, 3'd3, 4'd7,  1'b1, 1'b0},
        '{13'h0480, 13'h0000, 1'b1, 1'b0, 32'h0000_0010, 3'd1, 4'd0,  1'b0, 1'b0},
        '{13'h1FFF, 13'h1FFF, 1'b1, 1'b0, 32'hFFFF_FF00, 3'd4, 4'd12, 1'b1, 1'b1},
        '{13'h0000, 13'h1FFF, 1'b1, 1'b0, 32'h0000_0000, 3'd0, 4'd0,  1'b0, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          upd_vld;
    logic [3:0]    upd_idx;
    logic          upd_lvl;
    logic [N-1:0]  lie_mask;
    logic          glob_ie;
    logic          dbg_state;
    logic [2:0]    vec_space;
    logic [AW-1:0] entry_base;
    logic          hw_req;
    logic          wake;
    logic          take;
    logic [3:0]    vec_num;
    logic [AW-1:0] target_addr;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    irq_vec_ctrl u_irq_vec_ctrl (
        .clk         (clk),
        .rst         (rst),
        .upd_vld     (upd_vld),
        .upd_idx     (upd_idx),
        .upd_lvl     (upd_lvl),
        .lie_mask    (lie_mask),
        .glob_ie     (glob_ie),
        .dbg_state   (dbg_state),
        .vec_space   (vec_space),
        .entry_base  (entry_base),
        .hw_req      (hw_req),
        .wake        (wake),
        .take        (take),
        .vec_num     (vec_num),
        .target_addr (target_addr)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic write_line(input int idx, input logic lvl);
        upd_vld = 1'b1;
        upd_idx = 4'(idx);
        upd_lvl = lvl;
        tick();
        upd_vld = 1'b0;
    endtask

    task automatic load_status(input logic [N-1:0] pat);
        for (int i = 0; i < N; i++) begin
            write_line(i, pat[i]);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] exp_t;
        rst        = 1'b1;
        upd_vld    = 1'b0;
        upd_idx    = '0;
        upd_lvl    = 1'b0;
        lie_mask   = '0;
        glob_ie    = 1'b0;
        dbg_state  = 1'b0;
        vec_space  = 3'd1;
        entry_base = 32'h0;
        tick(); tick(); tick();
        rst = 1'b0;
        #1;
        // R10: reset state
        check("R10 hw_req after reset", 32'(hw_req), 32'd0);
        check("R10 wake after reset",   32'(wake),   32'd0);
        check("R10 take after reset",   32'(take),   32'd0);
        check("R10 vec after reset",    32'(vec_num), 32'd0);

        // Table walk
        foreach (TBL[k]) begin
            glob_ie   = 1'b0;
            dbg_state = 1'b0;
            tick();
            load_status(TBL[k].st);
            lie_mask = TBL[k].mk;
            tick();
            glob_ie    = TBL[k].ie;
            dbg_state  = TBL[k].dbg;
            entry_base = TBL[k].base;
            vec_space  = TBL[k].sp;
            #1;
            exp_t = TBL[k].base + (32'd64 + 32'(TBL[k].vec)) * 32'(TBL[k].sp);
            check($sformatf("R3 row%0d hw_req", k), 32'(hw_req), 32'(TBL[k].st != 13'h0));
            check($sformatf("R6 row%0d vector", k), 32'(vec_num), 32'(TBL[k].vec));
            check($sformatf("R8 row%0d wake", k),   32'(wake),    32'(TBL[k].wk));
            check($sformatf("R4 row%0d take", k),   32'(take),    32'(TBL[k].tk));
            check($sformatf("R7 row%0d target", k), target_addr,  exp_t);
            if (TBL[k].tk) begin
                tick();
                check($sformatf("R9 row%0d take one cycle", k), 32'(take), 32'd0);
            end
        end

        // R1: set and clear a single line
        glob_ie  = 1'b0;
        lie_mask = 13'h1FFF;
        load_status(13'h0000);
        write_line(5, 1'b1);
        check("R1 line 5 set vector", 32'(vec_num), 32'd5);
        check("R1 line 5 set hw_req", 32'(hw_req),  32'd1);
        write_line(5, 1'b0);
        check("R1 line 5 cleared",    32'(hw_req),  32'd0);

        // R2: out-of-range indices are ignored
        write_line(14, 1'b1);
        check("R2 idx 14 no set", 32'(hw_req), 32'd0);
        write_line(12, 1'b1);
        write_line(13, 1'b0);
        check("R2 idx 13 no clear", 32'(hw_req), 32'd1);
        write_line(15, 1'b0);
        check("R2 idx 15 no clear vector", 32'(vec_num), 32'd12);

        // R5: mask takes effect one edge later
        load_status(13'h0004);
        lie_mask = 13'h0000;
        tick();
        check("R5 masked off", 32'(wake), 32'd0);
        lie_mask = 13'h0004;
        #1;
        check("R5 mask not yet applied", 32'(wake), 32'd0);
        tick();
        check("R5 mask applied wake",   32'(wake),    32'd1);
        check("R5 mask applied vector", 32'(vec_num), 32'd2);

        // R8: wake ignores enables
        glob_ie   = 1'b0;
        dbg_state = 1'b1;
        #1;
        check("R8 wake with ie=0 dbg=1", 32'(wake), 32'd1);
        check("R4 no take with ie=0",    32'(take), 32'd0);
        tick();
        glob_ie = 1'b1;
        #1;
        check("R4 no take in debug", 32'(take), 32'd0);

        // R9: rise, hold, drop, re-arm
        tick();
        dbg_state = 1'b0;
        #1;
        check("R9 take on rise", 32'(take), 32'd1);
        tick();
        check("R9 take held low", 32'(take), 32'd0);
        tick();
        check("R9 take still low", 32'(take), 32'd0);
        glob_ie = 1'b0;
        tick();
        glob_ie = 1'b1;
        #1;
        check("R9 take re-armed", 32'(take), 32'd1);

        // R10: reset mid-run clears status
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        check("R10 hw_req after mid reset", 32'(hw_req), 32'd0);
        check("R10 take after mid reset",   32'(take),   32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule